// File: doc/BRIEF.md
# Single-Channel DMA Register Block with Pointer Engine

This block is the software-visible face of one DMA channel. A processor reaches it over a simple 32-bit memory-mapped request port. The block holds five buffer pointers and a status word. The status word is not stored as written. Each write to it is read as a set of commands, and each command either raises or drops one of four flags: enable, single-update, complete and device-to-memory.

A small engine sits behind the registers. Each time the outside world signals a transfer beat, the engine moves the current pointer forward by one word for as long as the channel is enabled. When the pointer lands on the limit, the engine marks the transfer complete and pulses an interrupt. What happens next depends on the single-update flag. If it is set, the channel stops. If it is clear, the engine reloads the current pointer and the limit from the start and stop registers and keeps running. The current pointer, the enable flag and the direction flag are also driven out on ports, so that a bus master outside this block can act on them.

Top module: `dmac_chan`

## Requirements
- R1: After reset, all four flags, all pointer registers and `done_irq` are zero, and every register reads back as zero.
- R2: A status write with bit 0 set sets the enable flag. A status write with bit 0 clear leaves the enable flag as it was.
- R3: A status write with bit 1 set sets the single-update flag. A write with bit 1 clear leaves that flag as it was.
- R4: A status write with bit 2 set clears the complete flag.
- R5: A status write with bit 3 set clears all four flags at once. This reset command wins over any set command carried in the same write.
- R6: A status write with bit 4 set sets the device-to-memory flag. A write with bit 4 clear does not clear it; only the reset command (R5) can.
- R7: The registers sit at these offsets: status at 0x0000, current pointer at 0x4000, limit at 0x4004, start at 0x4008, stop at 0x400C and initial-pointer buffer at 0x4200. Each pointer register reads back the last value written to it. A status read returns enable in bit 0, single-update in bit 1, complete in bit 2 and device-to-memory in bit 3, with every other bit zero.
- R8: Read data appears with `bus_rvalid` high on the cycle after the read request. A read of an unmapped offset returns zero, and a write to an unmapped offset changes no register.
- R9: Only word accesses (`bus_size` = 2) are accepted. A write of any other size is ignored, and a read of any other size returns zero.
- R10: While the channel is enabled, each cycle with `xfer_beat` high adds 4 to the current pointer. A beat while the channel is disabled leaves the pointer unchanged.
- R11: When an advance makes the current pointer equal the limit, the complete flag is set and `done_irq` goes high for one cycle. If single-update is set, the enable flag is cleared at the same time.
- R12: When an advance reaches the limit and single-update is clear, the current pointer is loaded from start and the limit is loaded from stop, and the channel stays enabled.
- R13: A status read issued on the cycle right after an engine event already returns the updated flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the channel |
| bus_size | input | 2 | Access size code; 2 = 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| xfer_beat | input | 1 | One transfer word completed |
| cur_addr | output | 32 | Current pointer |
| chan_active | output | 1 | Enable flag |
| dir_to_mem | output | 1 | Device-to-memory flag |
| done_irq | output | 1 | One-cycle pulse when the pointer reaches the limit |

## Verification
The engine is exercised three ways: beats while the channel is disabled, which must leave the pointer alone; a single-update run that must stop exactly at the limit; and a chained run that must reload twice. Comparing the two kinds of run separates the stop-at-limit path from the reload path. The command decoder is driven with writes carrying a single bit, writes with all bits clear and one write that sets every bit together with reset. Between them these expose a flag that is stored directly instead of being set, a missing sticky behaviour, and the wrong precedence between reset and the set commands. Reads of odd sizes and of unmapped offsets check that the decoder rejects what it must.

// File: rtl/dmac_pkg.sv
// Package: shared offsets, command/status bit positions and types for the
// single-channel DMA register block. Assumes a byte-addressed, 32-bit port.
package dmac_pkg;
    localparam int WORD_W = 32;
    localparam int SIZE_W = 2;

    localparam logic [15:0] OFS_CSR   = 16'h0000;
    localparam logic [15:0] OFS_NEXT  = 16'h4000;
    localparam logic [15:0] OFS_LIMIT = 16'h4004;
    localparam logic [15:0] OFS_START = 16'h4008;
    localparam logic [15:0] OFS_STOP  = 16'h400C;
    localparam logic [15:0] OFS_INIT  = 16'h4200;

    localparam logic [SIZE_W-1:0] SZ_WORD = 2'd2;

    // command bits in a status write
    localparam int CMD_ENA    = 0;
    localparam int CMD_SINGLE = 1;
    localparam int CMD_CLRDN  = 2;
    localparam int CMD_RESET  = 3;
    localparam int CMD_DIR    = 4;
    localparam int CMD_W      = 5;

    // flag bits in a status read
    localparam int ST_ENA    = 0;
    localparam int ST_SINGLE = 1;
    localparam int ST_DONE   = 2;
    localparam int ST_DIR    = 3;

    // number of plain (software-only) pointer registers: start, stop, init
    localparam int N_PLAIN = 3;
    localparam int PL_START = 0;
    localparam int PL_STOP  = 1;
    localparam int PL_INIT  = 2;

    typedef enum logic [2:0] {
        REG_NONE, REG_CSR, REG_NEXT, REG_LIMIT, REG_START, REG_STOP, REG_INIT
    } reg_id_e;

    typedef struct packed {
        logic to_mem;
        logic done;
        logic single;
        logic ena;
    } flags_t;
endpackage

// File: rtl/dmac_regdec.sv
// Register decoder: maps a byte offset to a register identifier and flags
// whether the access size is a full word. Purely combinational.
// Assumes ADDR_W is at least 15 so every offset is representable.
module dmac_regdec import dmac_pkg::*; #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output reg_id_e           reg_id,
    output logic              word_ok
);
    // Purpose: select the addressed register from the offset.
    always_comb begin
        if (addr == ADDR_W'(OFS_CSR))        reg_id = REG_CSR;
        else if (addr == ADDR_W'(OFS_NEXT))  reg_id = REG_NEXT;
        else if (addr == ADDR_W'(OFS_LIMIT)) reg_id = REG_LIMIT;
        else if (addr == ADDR_W'(OFS_START)) reg_id = REG_START;
        else if (addr == ADDR_W'(OFS_STOP))  reg_id = REG_STOP;
        else if (addr == ADDR_W'(OFS_INIT))  reg_id = REG_INIT;
        else                                 reg_id = REG_NONE;
    end

    // Purpose: accept only 32-bit accesses.
    assign word_ok = (size == SZ_WORD);
endmodule

// File: rtl/dmac_flags.sv
// Status flags: interprets each status write as commands (sets, clears and
// a reset of all four flags) and applies the engine's limit event.
// Assumes the command in a write takes precedence over an engine event in
// the same cycle, and that reset in a write overrides the set commands.
module dmac_flags import dmac_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd,
    input  logic             hit,
    output flags_t           flags
);
    flags_t nxt;

    // Purpose: next flag state from the engine event, then the write commands.
    always_comb begin
        nxt = flags;
        if (hit) begin
            nxt.done = 1'b1;
            if (flags.single) nxt.ena = 1'b0;
        end
        if (cmd_we) begin
            if (cmd[CMD_DIR])    nxt.to_mem = 1'b1;
            if (cmd[CMD_ENA])    nxt.ena    = 1'b1;
            if (cmd[CMD_SINGLE]) nxt.single = 1'b1;
            if (cmd[CMD_CLRDN])  nxt.done   = 1'b0;
            if (cmd[CMD_RESET])  nxt        = '0;
        end
    end

    // Purpose: hold the flags, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= nxt;
    end
endmodule

// File: rtl/dmac_ptrs.sv
// Pointer engine: holds current, limit and the plain pointer registers,
// advances the current pointer on enabled beats and detects the limit.
// Assumes a bus write to a pointer wins over an engine update in the same
// cycle. The limit test is an exact equality after the advance.
module dmac_ptrs import dmac_pkg::*; #(
    parameter int STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_next,
    input  logic              wr_limit,
    input  logic [N_PLAIN-1:0] wr_plain,
    input  logic [WORD_W-1:0] wdata,
    input  logic              active,
    input  logic              single,
    input  logic              beat,
    output logic [WORD_W-1:0] next_q,
    output logic [WORD_W-1:0] limit_q,
    output logic [WORD_W-1:0] plain_q [N_PLAIN],
    output logic              hit
);
    localparam logic [WORD_W-1:0] STEP_V = WORD_W'(STEP);

    logic [WORD_W-1:0] adv;
    logic              go;
    logic              reload;

    // Purpose: advance value, beat qualification and limit detection.
    always_comb begin
        adv    = next_q + STEP_V;
        go     = active && beat;
        hit    = go && (adv == limit_q);
        reload = hit && !single;
    end

    // Purpose: current pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)      next_q <= '0;
        else if (wr_next) next_q <= wdata;
        else if (reload) next_q <= plain_q[PL_START];
        else if (go)     next_q <= adv;
    end

    // Purpose: limit register, reloaded from stop when chaining.
    always_ff @(posedge clk) begin
        if (!rst_n)       limit_q <= '0;
        else if (wr_limit) limit_q <= wdata;
        else if (reload)  limit_q <= plain_q[PL_STOP];
    end

    // Purpose: plain registers written only from the bus.
    for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
        always_ff @(posedge clk) begin
            if (!rst_n)          plain_q[g] <= '0;
            else if (wr_plain[g]) plain_q[g] <= wdata;
        end
    end
endmodule

// File: rtl/dmac_chan.sv
// Top: one DMA channel register block. Decodes word accesses, routes
// writes to the flag and pointer logic, returns registered read data one
// cycle after a read, and pulses done_irq on the cycle after the limit event.
module dmac_chan import dmac_pkg::*; #(
    parameter int ADDR_W = 16,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              xfer_beat,
    output logic [WORD_W-1:0] cur_addr,
    output logic              chan_active,
    output logic              dir_to_mem,
    output logic              done_irq
);
    reg_id_e           reg_id;
    logic              word_ok;
    logic              wr_ok;
    logic              rd_ok;
    flags_t            flags;
    logic              hit;
    logic [WORD_W-1:0] next_q;
    logic [WORD_W-1:0] limit_q;
    logic [WORD_W-1:0] plain_q [N_PLAIN];
    logic [N_PLAIN-1:0] wr_plain;
    logic [WORD_W-1:0] csr_view;
    logic [WORD_W-1:0] rd_mux;

    dmac_regdec #(.ADDR_W(ADDR_W)) dec_i (
        .addr    (bus_addr),
        .size    (bus_size),
        .reg_id  (reg_id),
        .word_ok (word_ok)
    );

    // Purpose: qualify accesses with the size check.
    assign wr_ok = bus_valid && bus_write && word_ok;
    assign rd_ok = bus_valid && !bus_write && word_ok;

    // Purpose: write strobes for the plain pointer registers.
    assign wr_plain[PL_START] = wr_ok && (reg_id == REG_START);
    assign wr_plain[PL_STOP]  = wr_ok && (reg_id == REG_STOP);
    assign wr_plain[PL_INIT]  = wr_ok && (reg_id == REG_INIT);

    dmac_flags flags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_we (wr_ok && (reg_id == REG_CSR)),
        .cmd    (bus_wdata[CMD_W-1:0]),
        .hit    (hit),
        .flags  (flags)
    );

    dmac_ptrs #(.STEP(STEP)) ptrs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_next  (wr_ok && (reg_id == REG_NEXT)),
        .wr_limit (wr_ok && (reg_id == REG_LIMIT)),
        .wr_plain (wr_plain),
        .wdata    (bus_wdata),
        .active   (flags.ena),
        .single   (flags.single),
        .beat     (xfer_beat),
        .next_q   (next_q),
        .limit_q  (limit_q),
        .plain_q  (plain_q),
        .hit      (hit)
    );

    // Purpose: pack the live flags into the status read layout.
    always_comb begin
        csr_view            = '0;
        csr_view[ST_ENA]    = flags.ena;
        csr_view[ST_SINGLE] = flags.single;
        csr_view[ST_DONE]   = flags.done;
        csr_view[ST_DIR]    = flags.to_mem;
    end

    // Purpose: read data selection, zero for unmapped offsets.
    always_comb begin
        unique case (reg_id)
            REG_CSR:   rd_mux = csr_view;
            REG_NEXT:  rd_mux = next_q;
            REG_LIMIT: rd_mux = limit_q;
            REG_START: rd_mux = plain_q[PL_START];
            REG_STOP:  rd_mux = plain_q[PL_STOP];
            REG_INIT:  rd_mux = plain_q[PL_INIT];
            default:   rd_mux = '0;
        endcase
    end

    // Purpose: registered read response and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            done_irq   <= 1'b0;
        end else begin
            bus_rvalid <= bus_valid && !bus_write;
            bus_rdata  <= rd_ok ? rd_mux : '0;
            done_irq   <= hit;
        end
    end

    assign cur_addr    = next_q;
    assign chan_active = flags.ena;
    assign dir_to_mem  = flags.to_mem;
endmodule

// File: rtl/dmac_chan_chk.sv
// Checker: temporal properties over the channel's ports, bound to dmac_chan.
module dmac_chan_chk #(
    parameter int ADDR_W = 16,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              xfer_beat,
    input logic [31:0]       cur_addr,
    input logic              chan_active,
    input logic              dir_to_mem,
    input logic              done_irq
);
    // R2
    ena_rise_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_active) |-> $past(bus_valid && bus_write && bus_size == 2'd2));

    // R6
    dir_clear_by_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dir_to_mem) |-> $past(bus_valid && bus_write && bus_wdata[3]));

    // R11
    irq_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $past(xfer_beat && chan_active));

    // R10
    beat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_beat && chan_active && !(bus_valid && bus_write))
        |=> ((cur_addr == $past(cur_addr) + 32'(STEP)) || done_irq));

    // R8
    read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    // R9
    narrow_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_size != 2'd2) |=> (bus_rdata == 32'd0));

    logic unused_addr;
    assign unused_addr = ^bus_addr;
endmodule

bind dmac_chan dmac_chan_chk #(.ADDR_W(ADDR_W), .STEP(STEP)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_size    (bus_size),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .xfer_beat   (xfer_beat),
    .cur_addr    (cur_addr),
    .chan_active (chan_active),
    .dir_to_mem  (dir_to_mem),
    .done_irq    (done_irq)
);

// File: tb/dmac_chan_tb_top.sv
`timescale 1ns/1ps
module dmac_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        xfer_beat = 1'b0;
    logic [31:0] cur_addr;
    logic        chan_active;
    logic        dir_to_mem;
    logic        done_irq;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    dmac_chan dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .xfer_beat(xfer_beat),
        .cur_addr(cur_addr), .chan_active(chan_active), .dir_to_mem(dir_to_mem),
        .done_irq(done_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'd2;
    endtask

    // driver: issue a read and push the expected item to the scoreboard
    task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag,
                      input logic [1:0] sz = 2'd2);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0; bus_size = 2'd2;
    endtask

    task automatic beats(input int n);
        xfer_beat = 1'b1;
        repeat (n) @(negedge clk);
        xfer_beat = 1'b0;
    endtask

    // monitor: pop and compare as read responses appear
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (exp_q.size() == 0) check("R8 unexpected response", 32'h1, 32'h0);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cur_addr", cur_addr, 32'h0);
        check("R1 active", {31'b0, chan_active}, 32'h0);
        check("R1 irq", {31'b0, done_irq}, 32'h0);
        rd(16'h0000, 32'h0, "R1 csr");
        rd(16'h4004, 32'h0, "R1 limit");
        rd(16'h4200, 32'h0, "R1 init");

        // R7 register map readback
        wr(16'h4000, 32'h0000_1000);
        wr(16'h4004, 32'h0000_1010);
        wr(16'h4008, 32'h0000_2000);
        wr(16'h400C, 32'h0000_2008);
        wr(16'h4200, 32'h0000_3000);
        rd(16'h4000, 32'h0000_1000, "R7 next");
        rd(16'h4004, 32'h0000_1010, "R7 limit");
        rd(16'h4008, 32'h0000_2000, "R7 start");
        rd(16'h400C, 32'h0000_2008, "R7 stop");
        rd(16'h4200, 32'h0000_3000, "R7 init");

        // R8 unmapped offset
        wr(16'h4010, 32'hDEAD_BEEF);
        rd(16'h4010, 32'h0, "R8 unmapped read");
        rd(16'h4000, 32'h0000_1000, "R8 unmapped write no effect");

        // R9 narrow accesses
        wr(16'h4000, 32'h0000_5555, 2'd1);
        rd(16'h4000, 32'h0000_1000, "R9 narrow write ignored");
        rd(16'h4000, 32'h0, "R9 narrow read zero", 2'd0);

        // R6 direction is sticky
        wr(16'h0000, 32'h10);
        rd(16'h0000, 32'h8, "R6 dir set");
        wr(16'h0000, 32'h00);
        rd(16'h0000, 32'h8, "R6 dir kept");
        // R2 enable
        wr(16'h0000, 32'h01);
        rd(16'h0000, 32'h9, "R2 enable set");
        wr(16'h0000, 32'h00);
        rd(16'h0000, 32'h9, "R2 enable kept");
        check("R2 active port", {31'b0, chan_active}, 32'h1);
        // R3 single-update
        wr(16'h0000, 32'h02);
        rd(16'h0000, 32'hB, "R3 single set");
        // R5 reset clears all, wins over sets
        wr(16'h0000, 32'h08);
        rd(16'h0000, 32'h0, "R5 reset");
        wr(16'h0000, 32'h1B);
        rd(16'h0000, 32'h0, "R5 reset wins");
        check("R6 dir port cleared", {31'b0, dir_to_mem}, 32'h0);

        // R10 beats while disabled
        beats(2);
        check("R10 disabled beats", cur_addr, 32'h0000_1000);

        // R11 single-update run
        wr(16'h0000, 32'h03);
        beats(1);
        check("R10 advance", cur_addr, 32'h0000_1004);
        check("R11 no early irq", {31'b0, done_irq}, 32'h0);
        beats(3);
        check("R11 stop at limit", cur_addr, 32'h0000_1010);
        check("R11 irq pulse", {31'b0, done_irq}, 32'h1);
        check("R11 enable cleared", {31'b0, chan_active}, 32'h0);
        rd(16'h0000, 32'h6, "R13 live flags");
        check("R11 irq one cycle", {31'b0, done_irq}, 32'h0);
        beats(1);
        check("R10 stopped", cur_addr, 32'h0000_1010);
        // R4 clear complete
        wr(16'h0000, 32'h04);
        rd(16'h0000, 32'h2, "R4 clear complete");

        // R12 chained run
        wr(16'h0000, 32'h08);
        wr(16'h4000, 32'h0000_1000);
        wr(16'h4004, 32'h0000_1008);
        wr(16'h0000, 32'h01);
        beats(1);
        check("R10 chain advance", cur_addr, 32'h0000_1004);
        beats(1);
        check("R12 reload next", cur_addr, 32'h0000_2000);
        check("R12 irq", {31'b0, done_irq}, 32'h1);
        check("R12 still active", {31'b0, chan_active}, 32'h1);
        rd(16'h4004, 32'h0000_2008, "R12 reload limit");
        rd(16'h0000, 32'h5, "R12 flags");
        beats(2);
        check("R12 second reload", cur_addr, 32'h0000_2000);
        check("R12 second irq", {31'b0, done_irq}, 32'h1);

        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule